// File: doc/BRIEF.md
# Multi-Mode Encoded Reference Divider

This block divides an incoming reference clock by an integer from 1 to 2055. The ratio is not written as a plain binary number. It comes from a 13-bit setting word whose two lowest bits choose how the remaining bits are read. A decoder turns the word into an integer ratio. A counter then runs one division period after another, and at the start of each period it raises a one-cycle enable pulse. It also drives a divided square-wave output whose high phase covers the first half of the period.

A new setting word is captured when the update strobe is high. The new ratio does not act straight away. It waits in a holding register until the period that is running ends, so that every output period has either the full old length or the full new length. A large-ratio code that decodes below the lowest ratio that mode may hold is flagged as illegal and is not captured. If several words arrive within one period, the last legal one is the one applied.

Top module: `refdiv_top`

## Requirements
- R1: When cfg_word[1:0] is 00 the ratio is 1, and when it is 01 the ratio is 2. Bits [12:2] are ignored in this mode.
- R2: When cfg_word[1:0] is 10, bits [5:2] hold the bitwise inverse of (N - 2), which gives N from 3 to 17 (for example, N=3 is written as [5:0]=111010 and N=17 as 000010). Bits [12:6] are ignored.
- R3: When cfg_word[1:0] is 11, bits [12:2] hold N - 8 in plain binary, which gives N from 18 to 2055 (for example, N=18 is written as [12:0]=0_0000_0010_1011).
- R4: A mode-11 word whose decoded value is below 18 is illegal. It raises cfg_bad, and the ratio previously captured is kept.
- R5: cfg_bad changes only in the cycle after a load. It is set by an illegal word and cleared by a legal one.
- R6: A captured ratio takes effect only when the running period ends. The running period always completes at its old length, so no period is cut short.
- R7: div_pulse is high for exactly one cycle per period, and the pulses are N cycles apart. With N=1, div_pulse stays high in every cycle.
- R8: div_clk is high for the first ceil(N/2) cycles of each period and low for the remaining cycles. div_pulse rises in the first high cycle of div_clk.
- R9: While reset is high, div_pulse, div_clk and cfg_bad are 0 and the ratio returns to 1.
- R10: When several legal words are loaded within one period, the last one is the ratio applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 13 | Encoded divide setting |
| cfg_load | input | 1 | Strobe that captures cfg_word |
| div_pulse | output | 1 | One-cycle enable at the start of each period |
| div_clk | output | 1 | Divided square-wave output |
| cfg_bad | output | 1 | The last word loaded was illegal |

## Verification
Each of the three encodings is tried at its edge ratios (1, 2, 3, 17, 18 and 2055) and at one ratio inside its range. Garbage is placed in the bits that mode ignores, which shows whether the decoder reads the wrong field or applies the wrong offset or inversion. Both the period length and the high-phase length are measured, so an error in the counter limit can be told apart from an error in the duty threshold. A word loaded partway through a 40-cycle period shows whether the switch waits for the period boundary. Two consecutive loads, one legal word followed by an illegal one and then two legal words, show whether an illegal code overwrites the held ratio and whether the last legal word wins.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  typedef enum logic [1:0] {
    MODE_ONE   = 2'b00,
    MODE_TWO   = 2'b01,
    MODE_SMALL = 2'b10,
    MODE_LARGE = 2'b11
  } refdiv_mode_e;

  localparam int SMALL_OFS = 2;
  localparam int LARGE_OFS = 8;
endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
  import refdiv_pkg::*;
#(
  parameter int CFG_W     = 13,
  parameter int RATIO_W   = 12,
  parameter int SMALL_W   = 4,
  parameter int MIN_LARGE = 18
) (
  input  logic [CFG_W-1:0]   word,
  output logic [RATIO_W-1:0] ratio,
  output logic               legal
);
  localparam int LARGE_W = CFG_W - 2;

  refdiv_mode_e         mode;
  logic [SMALL_W-1:0]   small_inv;
  logic [RATIO_W-1:0]   small_val;
  logic [RATIO_W-1:0]   large_val;

  assign mode      = refdiv_mode_e'(word[1:0]);
  assign small_inv = ~word[2 +: SMALL_W];
  assign small_val = RATIO_W'(small_inv) + RATIO_W'(SMALL_OFS);
  assign large_val = RATIO_W'(word[2 +: LARGE_W]) + RATIO_W'(LARGE_OFS);

  always_comb begin
    legal = 1'b1;
    unique case (mode)
      MODE_ONE:   ratio = RATIO_W'(1);
      MODE_TWO:   ratio = RATIO_W'(2);
      MODE_SMALL: ratio = small_val;
      MODE_LARGE: begin
        ratio = large_val;
        legal = (large_val >= RATIO_W'(MIN_LARGE));
      end
      default:    ratio = RATIO_W'(1);
    endcase
  end
endmodule

// File: rtl/refdiv_update.sv
module refdiv_update #(
  parameter int RATIO_W     = 12,
  parameter int RESET_RATIO = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic               legal,
  input  logic               period_end,
  output logic [RATIO_W-1:0] act_ratio,
  output logic [RATIO_W-1:0] act_next,
  output logic               cfg_bad
);
  logic [RATIO_W-1:0] pend_ratio;
  logic               pend_vld;
  logic               swap;

  assign swap     = period_end && pend_vld;
  assign act_next = swap ? pend_ratio : act_ratio;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_ratio  <= RATIO_W'(RESET_RATIO);
      pend_ratio <= RATIO_W'(RESET_RATIO);
      pend_vld   <= 1'b0;
      cfg_bad    <= 1'b0;
    end else begin
      if (swap) begin
        act_ratio <= pend_ratio;
        pend_vld  <= 1'b0;
      end
      if (load) begin
        if (legal) begin
          pend_ratio <= ratio_in;
          pend_vld   <= 1'b1;
          cfg_bad    <= 1'b0;
        end else begin
          cfg_bad    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int RATIO_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] act_ratio,
  input  logic [RATIO_W-1:0] act_next,
  output logic               period_end,
  output logic [RATIO_W-1:0] cnt,
  output logic               div_pulse,
  output logic               div_clk
);
  logic [RATIO_W-1:0] nxt_cnt;
  logic [RATIO_W-1:0] half;

  assign period_end = (cnt == act_ratio - RATIO_W'(1));
  assign nxt_cnt    = period_end ? '0 : cnt + RATIO_W'(1);
  assign half       = (act_next + RATIO_W'(1)) >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      div_pulse <= 1'b0;
      div_clk   <= 1'b0;
    end else begin
      cnt       <= nxt_cnt;
      div_pulse <= period_end;
      div_clk   <= (nxt_cnt < half);
    end
  end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
  parameter int CFG_W       = 13,
  parameter int RATIO_W     = 12,
  parameter int SMALL_W     = 4,
  parameter int RESET_RATIO = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             cfg_load,
  output logic             div_pulse,
  output logic             div_clk,
  output logic             cfg_bad
);
  localparam int MIN_LARGE = refdiv_pkg::SMALL_OFS + (2 ** SMALL_W);

  logic [RATIO_W-1:0] dec_ratio;
  logic               dec_legal;
  logic [RATIO_W-1:0] act_ratio;
  logic [RATIO_W-1:0] act_next;
  logic               period_end;
  logic [RATIO_W-1:0] cnt;

  refdiv_decode #(
    .CFG_W(CFG_W), .RATIO_W(RATIO_W), .SMALL_W(SMALL_W), .MIN_LARGE(MIN_LARGE)
  ) u_dec (
    .word(cfg_word), .ratio(dec_ratio), .legal(dec_legal)
  );

  refdiv_update #(
    .RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO)
  ) u_upd (
    .clk(clk), .rst(rst), .load(cfg_load), .ratio_in(dec_ratio),
    .legal(dec_legal), .period_end(period_end), .act_ratio(act_ratio),
    .act_next(act_next), .cfg_bad(cfg_bad)
  );

  refdiv_counter #(
    .RATIO_W(RATIO_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .act_ratio(act_ratio), .act_next(act_next),
    .period_end(period_end), .cnt(cnt), .div_pulse(div_pulse), .div_clk(div_clk)
  );
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
  parameter int CFG_W     = 13,
  parameter int RATIO_W   = 12,
  parameter int MIN_LARGE = 18
) (
  input logic               clk,
  input logic               rst,
  input logic [CFG_W-1:0]   cfg_word,
  input logic               cfg_load,
  input logic               div_pulse,
  input logic               div_clk,
  input logic               cfg_bad,
  input logic [RATIO_W-1:0] cnt,
  input logic [RATIO_W-1:0] act_ratio
);
  localparam int MAX_RATIO = (2 ** (CFG_W - 2)) - 1 + refdiv_pkg::LARGE_OFS;

  logic bad_code;
  logic [RATIO_W:0] gap;

  assign bad_code = (cfg_word[1:0] == 2'b11) &&
                    ((32'(cfg_word[CFG_W-1:2]) + refdiv_pkg::LARGE_OFS) < MIN_LARGE);

  always_ff @(posedge clk) begin
    if (rst || div_pulse) gap <= '0;
    else if (gap < (RATIO_W+1)'(MAX_RATIO + 1)) gap <= gap + 1'b1;
  end

  // R4
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load && bad_code |=> cfg_bad);

  // R5
  legal_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load && !bad_code |=> !cfg_bad);

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(cfg_bad));

  // R8
  pulse_in_high_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> div_clk);

  // R6
  count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < act_ratio);

  // R7
  pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
    gap < (RATIO_W+1)'(MAX_RATIO));
endmodule

bind refdiv_top refdiv_chk #(
  .CFG_W(CFG_W), .RATIO_W(RATIO_W), .MIN_LARGE(MIN_LARGE)
) u_chk (
  .clk(clk), .rst(rst), .cfg_word(cfg_word), .cfg_load(cfg_load),
  .div_pulse(div_pulse), .div_clk(div_clk), .cfg_bad(cfg_bad),
  .cnt(cnt), .act_ratio(act_ratio)
);

// File: tb/sim_refdiv_top.sv
module sim_refdiv_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] cfg_word = '0;
  logic        cfg_load = 1'b0;
  logic        div_pulse, div_clk, cfg_bad;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refdiv_top u0 (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .cfg_load(cfg_load),
    .div_pulse(div_pulse), .div_clk(div_clk), .cfg_bad(cfg_bad)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [12:0] enc_direct(input int n);
    return {11'h5A5, 1'b0, (n == 2)};
  endfunction

  function automatic logic [12:0] enc_small(input int n);
    logic [3:0] v;
    v = 4'(n - 2);
    return {7'h55, ~v, 2'b10};
  endfunction

  function automatic logic [12:0] enc_large(input int n);
    return {11'(n - 8), 2'b11};
  endfunction

  task automatic do_load(input logic [12:0] w);
    @(negedge clk);
    cfg_word = w; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic do_load2(input logic [12:0] w1, input logic [12:0] w2);
    @(negedge clk);
    cfg_word = w1; cfg_load = 1'b1;
    @(negedge clk);
    cfg_word = w2;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic skip_two;
    while (!div_pulse) @(negedge clk);
    @(negedge clk);
    while (!div_pulse) @(negedge clk);
  endtask

  task automatic measure(input int n, input string req);
    int len = 0;
    int hi = 0;
    while (!div_pulse) @(negedge clk);
    do begin
      len++;
      hi += int'(div_clk);
      @(negedge clk);
    end while (!div_pulse);
    chk(len == n, {req, " period"}, len, n);
    chk(hi == (n + 1) / 2, "R8 high phase", hi, (n + 1) / 2);
  endtask

  task automatic set_and_check(input logic [12:0] w, input int n, input string req);
    do_load(w);
    skip_two();
    measure(n, req);
    measure(n, req);
  endtask

  task automatic test_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(div_pulse == 1'b0, "R9 pulse", int'(div_pulse), 0);
    chk(div_clk == 1'b0, "R9 clk", int'(div_clk), 0);
    chk(cfg_bad == 1'b0, "R9 bad", int'(cfg_bad), 0);
    rst = 1'b0;
    @(negedge clk);
    measure(1, "R9 reset ratio");
    measure(1, "R7 ratio one");
  endtask

  task automatic test_modes;
    set_and_check(enc_direct(2), 2, "R1 direct 2");
    set_and_check(enc_direct(1), 1, "R1 direct 1");
    set_and_check(enc_small(3), 3, "R2 small 3");
    set_and_check(enc_small(10), 10, "R2 small 10");
    set_and_check(enc_small(17), 17, "R2 small 17");
    set_and_check(enc_large(18), 18, "R3 large 18");
    set_and_check(enc_large(1000), 1000, "R3 large 1000");
    set_and_check(enc_large(2055), 2055, "R3 large 2055");
  endtask

  task automatic test_illegal;
    set_and_check(enc_large(25), 25, "R3 large 25");
    do_load({11'd3, 2'b11});
    chk(cfg_bad == 1'b1, "R4 flag set", int'(cfg_bad), 1);
    measure(25, "R4 ratio kept");
    measure(25, "R4 ratio kept");
    chk(cfg_bad == 1'b1, "R5 flag held", int'(cfg_bad), 1);
    do_load(enc_small(6));
    chk(cfg_bad == 1'b0, "R5 flag cleared", int'(cfg_bad), 0);
    skip_two();
    measure(6, "R5 legal after illegal");
    set_and_check(enc_large(30), 30, "R3 large 30");
    do_load2(enc_small(7), {11'd0, 2'b11});
    chk(cfg_bad == 1'b1, "R4 flag after pair", int'(cfg_bad), 1);
    skip_two();
    measure(7, "R4 held ratio kept");
  endtask

  task automatic test_last_wins;
    set_and_check(enc_large(30), 30, "R3 large 30");
    do_load2(enc_small(9), enc_small(4));
    skip_two();
    measure(4, "R10 last wins");
    measure(4, "R10 last wins");
  endtask

  task automatic test_boundary;
    int len = 0;
    set_and_check(enc_large(40), 40, "R3 large 40");
    while (!div_pulse) @(negedge clk);
    do begin
      len++;
      if (len == 10) begin
        cfg_word = enc_small(3);
        cfg_load = 1'b1;
      end else begin
        cfg_load = 1'b0;
      end
      @(negedge clk);
    end while (!div_pulse);
    cfg_load = 1'b0;
    chk(len == 40, "R6 running period kept", len, 40);
    measure(3, "R6 first new period");
    measure(3, "R6 second new period");
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    test_reset();
    test_modes();
    test_illegal();
    test_last_wins();
    test_boundary();
    finish_sim();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_sim();
  end
endmodule